// File: doc/BRIEF.md
# Dual-Organization Bit Memory Core

This block is a single-clock static memory core built around one array of `DEPTH` storage bits. It has three active-low controls: chip select, write enable and output enable. A mode input decides how the array is seen on each access. In narrow mode every address selects one bit. In wide mode every address selects a group of four adjacent bits, so a full write-and-verify pass over the array needs only a quarter of the accesses. The same physical bits are visible in both views. Data written in one view can therefore be read back in the other.

Reads are registered. The read value and a drive flag appear one clock after the read strobe. The drive flag models the enable of an external three-state buffer, and the data lines are held at zero whenever the flag is low. The storage bits are never cleared by reset. `DEPTH` must be a power of four.

Top module: `dualorg_sram`

## Requirements
- R1: With `wide_mode` = 0, address `addr` selects the single bit `addr`. Write data is taken from `din[0]` and read data appears on `dout[0]`. During such a narrow read, `dout[3:1]` is 0.
- R2: With `wide_mode` = 1, the word address is `addr[ADDR_W-1:2]` and `addr[1:0]` is ignored. Data lane i (`din[i]` / `dout[i]`) maps to narrow bit `4*addr[ADDR_W-1:2] + i`.
- R3: While `cs_n` = 1, no bit is written, whatever `we_n`, `oe_n` and `din` are. One cycle later, `dout_en` is 0.
- R4: `cs_n` = 0 together with `we_n` = 0 writes on the clock edge, whatever `oe_n` is. One cycle later, `dout_en` is 0.
- R5: `cs_n` = 0, `we_n` = 1 and `oe_n` = 0 is a read: one cycle later, `dout_en` is 1 and `dout` carries the stored data. With `oe_n` = 1 instead, `dout_en` is 0 one cycle later.
- R6: Whenever `dout_en` is 0, `dout` is 0.
- R7: Changing `wide_mode` between accesses never alters the stored bits.
- R8: While `rst_n` is low, `dout_en` is 0 and `dout` is 0. Reset does not clear the stored bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| wide_mode | input | 1 | 0: one-bit words, 1: four-bit words |
| addr | input | ADDR_W | Bit address (narrow) or word address in the upper bits (wide) |
| din | input | 4 | Write data; only bit 0 is used in narrow mode |
| dout | output | 4 | Registered read data |
| dout_en | output | 1 | Drive flag for the read data |

## Verification
The hardest situation to reach from the ports is showing that the two views share one array. A wide write must land on exactly the four narrow bits it claims, and the same must hold in reverse, with the low address bits ignored in wide mode. The stimulus writes nibbles in one mode and reads them back bit by bit in the other, and also writes bits singly and reads them as nibbles with nonzero low address bits. It toggles the mode during deselected cycles and applies a mid-run reset, and only then rereads locations written earlier. A long random mix of modes and operations, checked against a bench-side bit model, covers the remaining combinations.

// File: rtl/dualorg_pkg.sv
package dualorg_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_MUTE  = 2'd3
    } op_e;

    typedef struct packed {
        logic       en;
        logic [3:0] data;
    } rd_out_t;
endpackage

// File: rtl/dualorg_ctrl.sv
module dualorg_ctrl
    import dualorg_pkg::*;
#(
    parameter int ADDR_W = 10,
    localparam int GRP_W = ADDR_W - 2
) (
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              wide_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        din,
    output op_e               op,
    output logic [GRP_W-1:0]  grp,
    output logic [1:0]        lane,
    output logic [3:0]        wr_mask,
    output logic [3:0]        wr_data
);
    always_comb begin
        if (cs_n)       op = OP_IDLE;
        else if (!we_n) op = OP_WRITE;
        else if (!oe_n) op = OP_READ;
        else            op = OP_MUTE;
    end

    assign grp  = addr[ADDR_W-1:2];
    assign lane = addr[1:0];

    always_comb begin
        wr_mask = 4'h0;
        wr_data = 4'h0;
        if (op == OP_WRITE) begin
            if (wide_mode) begin
                wr_mask = 4'hF;
                wr_data = din;
            end else begin
                wr_mask = 4'(1) << lane;
                wr_data = {4{din[0]}};
            end
        end
    end
endmodule

// File: rtl/dualorg_array.sv
module dualorg_array #(
    parameter int DEPTH = 1024,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int GRP_W  = ADDR_W - 2,
    localparam int GROUPS = DEPTH / 4
) (
    input  logic             clk,
    input  logic [GRP_W-1:0] grp,
    input  logic [3:0]       wr_mask,
    input  logic [3:0]       wr_data,
    output logic [3:0]       rd_nib
);
    logic [DEPTH-1:0] bits_w;

    for (genvar g = 0; g < GROUPS; g++) begin : g_cell
        logic [3:0] cell_d, cell_q;
        logic       hit;
        assign hit = (grp == GRP_W'(g));
        always_comb begin
            cell_d = cell_q;
            if (hit) begin
                for (int i = 0; i < 4; i++) begin
                    if (wr_mask[i]) cell_d[i] = wr_data[i];
                end
            end
        end
        always_ff @(posedge clk) begin
            cell_q <= cell_d;
        end
        assign bits_w[g*4 +: 4] = cell_q;
    end

    assign rd_nib = bits_w[{grp, 2'b00} +: 4];
endmodule

// File: rtl/dualorg_rdmux.sv
module dualorg_rdmux (
    input  logic       wide_mode,
    input  logic [1:0] lane,
    input  logic [3:0] rd_nib,
    output logic [3:0] rd_val
);
    always_comb begin
        if (wide_mode) rd_val = rd_nib;
        else           rd_val = {3'b000, rd_nib[lane]};
    end
endmodule

// File: rtl/dualorg_sram.sv
module dualorg_sram
    import dualorg_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int GRP_W  = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              wide_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        din,
    output logic [3:0]        dout,
    output logic              dout_en
);
    op_e              op;
    logic [GRP_W-1:0] grp;
    logic [1:0]       lane;
    logic [3:0]       wr_mask, wr_data, rd_nib, rd_val;
    rd_out_t          out_d, out_q;

    dualorg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n), .wide_mode(wide_mode),
        .addr(addr), .din(din), .op(op), .grp(grp), .lane(lane),
        .wr_mask(wr_mask), .wr_data(wr_data)
    );

    dualorg_array #(.DEPTH(DEPTH)) u_array (
        .clk(clk), .grp(grp), .wr_mask(wr_mask), .wr_data(wr_data),
        .rd_nib(rd_nib)
    );

    dualorg_rdmux u_rdmux (
        .wide_mode(wide_mode), .lane(lane), .rd_nib(rd_nib), .rd_val(rd_val)
    );

    always_comb begin
        out_d = '0;
        if (op == OP_READ) begin
            out_d.en   = 1'b1;
            out_d.data = rd_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign dout    = out_q.data;
    assign dout_en = out_q.en;
endmodule

// File: rtl/dualorg_sram_chk.sv
module dualorg_sram_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       we_n,
    input logic       oe_n,
    input logic       wide_mode,
    input logic [3:0] dout,
    input logic       dout_en
);
    AST_DESELECT_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !dout_en); // R3
    AST_WRITE_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !we_n) |=> !dout_en); // R4
    AST_READ_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && we_n && !oe_n) |=> dout_en); // R5
    AST_OE_HIGH_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && we_n && oe_n) |=> !dout_en); // R5
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && we_n && !oe_n && !wide_mode) |=> (dout[3:1] == 3'b000)); // R1
    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == 4'h0)); // R6
endmodule

bind dualorg_sram dualorg_sram_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .wide_mode(wide_mode), .dout(dout), .dout_en(dout_en)
);

// File: tb/test_dualorg_sram.sv
module test_dualorg_sram;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 1024;
    localparam int ADDR_W     = $clog2(DEPTH);
    localparam int WATCHDOG   = 100000;

    typedef struct {
        logic       en;
        logic [3:0] data;
        string      req;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, wide_mode = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [3:0]        din = '0;
    logic [3:0]        dout;
    logic              dout_en;

    exp_t   sb_q[$];
    logic   model [DEPTH];
    int     tests = 0, fails = 0;
    bit     done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dualorg_sram #(.DEPTH(DEPTH)) i_dualorg_sram (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
        .wide_mode(wide_mode), .addr(addr), .din(din), .dout(dout),
        .dout_en(dout_en)
    );

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {en,dout} actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Driver: one access per cycle, expected result pushed to the scoreboard
    task automatic access(input logic c, input logic w, input logic o, input logic wd,
                          input logic [ADDR_W-1:0] a, input logic [3:0] d, input string req);
        exp_t e;
        logic [ADDR_W-1:0] base;
        @(negedge clk);
        cs_n = c; we_n = w; oe_n = o; wide_mode = wd; addr = a; din = d;
        base = {a[ADDR_W-1:2], 2'b00};
        e.en = 1'b0; e.data = 4'h0; e.req = req;
        if (!c && !w) begin
            if (wd) for (int i = 0; i < 4; i++) model[base + ADDR_W'(i)] = d[i];
            else    model[a] = d[0];
        end else if (!c && !o) begin
            e.en = 1'b1;
            if (wd) for (int i = 0; i < 4; i++) e.data[i] = model[base + ADDR_W'(i)];
            else    e.data = {3'b000, model[a]};
        end
        sb_q.push_back(e);
    endtask

    task automatic drain();
        @(negedge clk);
        cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    // Monitor: compare one cycle after each access
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() != 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.req, {dout_en, dout}, {e.en, e.data});
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset", {dout_en, dout}, 5'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: narrow writes then narrow reads of bits 0..15
        for (int k = 0; k < 16; k++)
            access(0, 0, 1, 0, ADDR_W'(k), {3'b101, 1'((k * 5 + 1) % 3 == 0)}, "R1 write");
        for (int k = 0; k < 16; k++)
            access(0, 1, 0, 0, ADDR_W'(k), 4'h0, "R1 narrow read");

        // R2: wide write, narrow read of the four bits
        access(0, 0, 1, 1, ADDR_W'(20), 4'b1010, "R2 wide write");
        for (int i = 0; i < 4; i++)
            access(0, 1, 0, 0, ADDR_W'(20 + i), 4'h0, "R2 narrow view of wide word");
        // narrow writes, wide read with nonzero low address bits
        access(0, 0, 1, 0, ADDR_W'(40), 4'h1, "R2 narrow write");
        access(0, 0, 1, 0, ADDR_W'(41), 4'h0, "R2 narrow write");
        access(0, 0, 1, 0, ADDR_W'(42), 4'h0, "R2 narrow write");
        access(0, 0, 1, 0, ADDR_W'(43), 4'h1, "R2 narrow write");
        access(0, 1, 0, 1, ADDR_W'(43), 4'h0, "R2 wide read low bits ignored");
        access(0, 0, 1, 1, ADDR_W'(62), 4'b0110, "R2 wide write low bits ignored");
        access(0, 1, 0, 1, ADDR_W'(60), 4'h0, "R2 wide read");

        // R4: write with oe_n low still writes and does not drive
        access(0, 0, 0, 1, ADDR_W'(80), 4'b1100, "R4 write with oe low");
        access(0, 1, 0, 1, ADDR_W'(80), 4'h0, "R4 readback");

        // R3: deselected write attempt changes nothing
        access(1, 0, 0, 1, ADDR_W'(80), 4'b0011, "R3 deselected");
        access(1, 1, 0, 0, ADDR_W'(80), 4'h0, "R3 deselected read");
        access(0, 1, 0, 1, ADDR_W'(80), 4'h0, "R3 contents unchanged");

        // R5: oe_n high read gives no drive
        access(0, 1, 1, 1, ADDR_W'(80), 4'h0, "R5 oe high");
        access(0, 1, 0, 1, ADDR_W'(80), 4'h0, "R5 read drives");

        // R7: toggle mode while idle, then reread
        for (int i = 0; i < 6; i++)
            access(1, 1, 1, 1'(i), ADDR_W'(i), 4'h0, "R7 mode toggle idle");
        access(0, 1, 0, 1, ADDR_W'(20), 4'h0, "R7 contents kept");
        access(0, 1, 0, 0, ADDR_W'(43), 4'h0, "R7 contents kept");

        // R8: reset in mid-run does not clear the array
        drain();
        rst_n = 1'b0;
        #2;
        check("R8 reset output", {dout_en, dout}, 5'b0);
        @(negedge clk);
        rst_n = 1'b1;
        access(0, 1, 0, 1, ADDR_W'(80), 4'h0, "R8 array kept over reset");
        access(0, 1, 0, 1, ADDR_W'(60), 4'h0, "R8 array kept over reset");

        // Random mix over a small region, all with known contents
        for (int k = 0; k < 128; k++)
            access(0, 0, 1, 0, ADDR_W'(256 + k), 4'($urandom), "R1 fill");
        for (int n = 0; n < 600; n++) begin
            logic [3:0] r;
            r = 4'($urandom);
            access(r[0], r[1], r[2], r[3], ADDR_W'(256 + ($urandom % 128)),
                   4'($urandom), "R6 random mix");
        end

        drain();
        repeat (2) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule